// File: doc/BRIEF.md
# Safety-Gated Enable Output Controller

This block decides the level of one safety-relevant output pin. The pin can serve as an enable for a downstream power stage, as an interrupt line to a host processor, or both. The pin is driven high only when three conditions hold together. The device must be in one of its two permitted operating states. An enable bit written by software must be set. The watchdog failure count must be below a programmable activation threshold. If any one of these conditions fails, the pin drops low in the same cycle.

A running analog self-test forces a high pin low for the length of the test pulse. This happens only when at least one over-temperature interrupt enable is set. The self-test never alters the enable bit or the device state, so the pin rises again once the test ends. While the block drives the pin high, it watches a synchronized readback of the pin to detect contention from an external pull-down. The monitor is blanked for a short window after every rising drive edge. A detected error sets a sticky flag, which is cleared by a write-one-to-clear strobe, and increments a saturating error counter.

The controller is a four-state machine:
- **IDLE** holds the pin low.
- **BLANK** drives the pin high while the monitor is masked.
- **MONITOR** drives the pin high with the monitor armed.
- **TEST_LOW** holds the pin low for the self-test.

The transitions are:
- **activate**: IDLE→BLANK when the enable is permitted.
- **settle**: BLANK→MONITOR after the blanking window.
- **test_enter**: BLANK or MONITOR→TEST_LOW when the self-test forces the pin.
- **test_release**: TEST_LOW→BLANK when the force ends.
- **revoke**: any state→IDLE when the enable is no longer permitted.

Top module: `safe_enable_ctrl`

## Requirements
- R1: After reset, drv_high is 0, drv_err is 0 and err_count is 0.
- R2: drv_high can be 1 only while dev_state equals 2 (diagnostic) or 3 (active). Every other 3-bit code keeps the pin low.
- R3: drv_high can be 1 only while enable_bit is 1.
- R4: drv_high can be 1 only while wd_fail_cnt is strictly less than act_thresh. A count equal to the threshold keeps the pin low.
- R5: When all conditions become true, drv_high rises one clock later. When any condition becomes false, drv_high falls in the same cycle, with no clock edge needed.
- R6: While selftest_run is 1 and at least one bit of ot_irq_en is set, drv_high is 0. If ot_irq_en is all zero, selftest_run has no effect on the pin. When the test ends, drv_high returns to 1 one clock later without any rewrite of enable_bit.
- R7: No error is recorded while the pin is forced low by the self-test. No error is recorded during the first BLANK_CYC (default 4) cycles after drv_high rises, whether from activation or from a self-test release.
- R8: Once the blanking window has passed, a pin readback of 0 while drv_high is 1 sets drv_err three clocks after the pin goes low (two synchronizer stages plus the flag register). drv_err holds until err_clr is pulsed. A new error in the same cycle as err_clr takes priority over the clear.
- R9: err_count increments once for each distinct low episode of the pin. It saturates at 15 and is not cleared by err_clr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_state | input | 3 | Current device operating state code |
| enable_bit | input | 1 | Software-written output enable |
| wd_fail_cnt | input | 4 | Watchdog failure count |
| act_thresh | input | 4 | Activation threshold for the failure count |
| selftest_run | input | 1 | Analog self-test pulse in progress |
| ot_irq_en | input | 4 | Over-temperature warning interrupt enables |
| pin_level | input | 1 | Asynchronous readback of the output pin |
| err_clr | input | 1 | Write-one-to-clear strobe for drv_err |
| drv_high | output | 1 | Output pin drive level |
| drv_err | output | 1 | Sticky driver contention flag |
| err_count | output | 4 | Saturating count of contention episodes |

## Verification
The embedded assertions check the static gating rules on every cycle:
- the pin never drives high outside a permitted state, without the enable bit, or at or above the threshold;
- the pin is always low while the self-test forces it;
- the error flag stays sticky;
- the counter stays at saturation;
- the monitor is never armed in TEST_LOW.

Only the directed scenarios can show the timing-dependent behaviour:
- the one-cycle activation latency;
- the exact cycle in which the contention flag appears after the synchronizer;
- that blanking masks the pin's own rising edge;
- that the pin recovers after a self-test without software action;
- that a set wins over a simultaneous clear.

// File: rtl/sec_pkg.sv
package sec_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BLANK = 2'd1,
        ST_MON   = 2'd2,
        ST_TEST  = 2'd3
    } drv_state_e;
endpackage

// File: rtl/sec_sync.sv
module sec_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/sec_drive_fsm.sv
module sec_drive_fsm
    import sec_pkg::*;
#(
    parameter int BLANK_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic permit,
    input  logic test_force,
    output logic drv_high,
    output logic mon_active
);
    localparam int BW = $clog2(BLANK_CYC + 1);
    localparam logic [BW-1:0] BLANK_LAST = BW'(BLANK_CYC - 1);

    drv_state_e state_q, state_d;
    logic [BW-1:0] blank_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            blank_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != ST_BLANK) blank_q <= '0;
            else                     blank_q <= blank_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (permit) state_d = ST_BLANK;
            ST_BLANK: begin
                if (!permit)                  state_d = ST_IDLE;
                else if (test_force)          state_d = ST_TEST;
                else if (blank_q == BLANK_LAST) state_d = ST_MON;
            end
            ST_MON: begin
                if (!permit)         state_d = ST_IDLE;
                else if (test_force) state_d = ST_TEST;
            end
            ST_TEST: begin
                if (!permit)         state_d = ST_IDLE;
                else if (!test_force) state_d = ST_BLANK;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        drv_high   = 1'b0;
        mon_active = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_BLANK: drv_high = permit & ~test_force;
            ST_MON: begin
                drv_high   = permit & ~test_force;
                mon_active = permit & ~test_force;
            end
            ST_TEST:  ;
            default:  ;
        endcase
    end

    a_r7_no_mon_in_test: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TEST) |-> !mon_active);
    a_r7_blank_masks: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BLANK) |-> !mon_active);
endmodule

// File: rtl/sec_err_mon.sv
module sec_err_mon #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mon_active,
    input  logic             pin_sync,
    input  logic             err_clr,
    output logic             err_flag,
    output logic [CNT_W-1:0] err_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic det, det_q;
    assign det = mon_active & ~pin_sync;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_q    <= 1'b0;
            err_flag <= 1'b0;
            err_cnt  <= '0;
        end else begin
            det_q <= det;
            if (det)          err_flag <= 1'b1;
            else if (err_clr) err_flag <= 1'b0;
            if (det && !det_q && err_cnt != CNT_MAX) err_cnt <= err_cnt + 1'b1;
        end
    end

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> err_flag);
    a_r8_set_on_det: assert property (@(posedge clk) disable iff (!rst_n)
        det |=> err_flag);
    a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cnt == CNT_MAX) |=> (err_cnt == CNT_MAX));
    a_r9_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cnt != CNT_MAX) |=> (err_cnt == $past(err_cnt) || err_cnt == $past(err_cnt) + 1'b1));
endmodule

// File: rtl/safe_enable_ctrl.sv
module safe_enable_ctrl #(
    parameter int STATE_W     = 3,
    parameter int DIAG_CODE   = 2,
    parameter int ACTIVE_CODE = 3,
    parameter int THR_W       = 4,
    parameter int OT_W        = 4,
    parameter int BLANK_CYC   = 4,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STATE_W-1:0] dev_state,
    input  logic               enable_bit,
    input  logic [THR_W-1:0]   wd_fail_cnt,
    input  logic [THR_W-1:0]   act_thresh,
    input  logic               selftest_run,
    input  logic [OT_W-1:0]    ot_irq_en,
    input  logic               pin_level,
    input  logic               err_clr,
    output logic               drv_high,
    output logic               drv_err,
    output logic [CNT_W-1:0]   err_count
);
    localparam logic [STATE_W-1:0] DIAG_V   = STATE_W'(DIAG_CODE);
    localparam logic [STATE_W-1:0] ACTIVE_V = STATE_W'(ACTIVE_CODE);

    logic state_ok, permit, test_force, pin_sync, mon_active;

    assign state_ok   = (dev_state == DIAG_V) || (dev_state == ACTIVE_V);
    assign permit     = state_ok & enable_bit & (wd_fail_cnt < act_thresh);
    assign test_force = selftest_run & (|ot_irq_en);

    sec_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_level),
        .q_sync  (pin_sync)
    );

    sec_drive_fsm #(.BLANK_CYC(BLANK_CYC)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .permit     (permit),
        .test_force (test_force),
        .drv_high   (drv_high),
        .mon_active (mon_active)
    );

    sec_err_mon #(.CNT_W(CNT_W)) u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .mon_active (mon_active),
        .pin_sync   (pin_sync),
        .err_clr    (err_clr),
        .err_flag   (drv_err),
        .err_cnt    (err_count)
    );

    a_r2_state_gate: assert property (@(posedge clk) disable iff (!rst_n)
        drv_high |-> (dev_state == DIAG_V || dev_state == ACTIVE_V));
    a_r3_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
        drv_high |-> enable_bit);
    a_r4_wd_gate: assert property (@(posedge clk) disable iff (!rst_n)
        drv_high |-> (wd_fail_cnt < act_thresh));
    a_r6_test_low: assert property (@(posedge clk) disable iff (!rst_n)
        (selftest_run && (|ot_irq_en)) |-> !drv_high);
endmodule

// File: tb/safe_enable_ctrl_test.sv
module safe_enable_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] dev_state = 3'd0;
    logic       enable_bit = 1'b0;
    logic [3:0] wd_fail_cnt = 4'd0;
    logic [3:0] act_thresh = 4'd4;
    logic       selftest_run = 1'b0;
    logic [3:0] ot_irq_en = 4'd0;
    logic       err_clr = 1'b0;
    logic       pull_low = 1'b0;
    logic       pin_level;
    logic       drv_high, drv_err;
    logic [3:0] err_count;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    assign pin_level = drv_high & ~pull_low;

    safe_enable_ctrl uut (
        .clk(clk), .rst_n(rst_n), .dev_state(dev_state), .enable_bit(enable_bit),
        .wd_fail_cnt(wd_fail_cnt), .act_thresh(act_thresh), .selftest_run(selftest_run),
        .ot_irq_en(ot_irq_en), .pin_level(pin_level), .err_clr(err_clr),
        .drv_high(drv_high), .drv_err(drv_err), .err_count(err_count)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    task automatic go_idle();
        @(negedge clk);
        enable_bit = 1'b0; selftest_run = 1'b0; pull_low = 1'b0; err_clr = 1'b0;
        step(2);
    endtask

    task automatic go_monitor();
        @(negedge clk);
        dev_state = 3'd3; enable_bit = 1'b1; wd_fail_cnt = 4'd0; act_thresh = 4'd4;
        step(8);
    endtask

    task automatic t_reset();
        check("R1 drv_high", drv_high, 0);
        check("R1 drv_err", drv_err, 0);
        check("R1 err_count", err_count, 0);
    endtask

    task automatic t_state_gate();
        @(negedge clk);
        enable_bit = 1'b1; wd_fail_cnt = 4'd0; act_thresh = 4'd4;
        for (int s = 0; s < 8; s++) begin
            dev_state = 3'(s);
            step(3);
            check($sformatf("R2 state %0d", s), drv_high, (s == 2 || s == 3) ? 1 : 0);
            @(negedge clk);
        end
        go_idle();
    endtask

    task automatic t_enable();
        @(negedge clk);
        dev_state = 3'd2; enable_bit = 1'b0;
        step(3);
        check("R3 enable clear", drv_high, 0);
        enable_bit = 1'b1;
        step(1);
        check("R5 rise after one clock", drv_high, 1);
        go_idle();
    endtask

    task automatic t_threshold();
        @(negedge clk);
        dev_state = 3'd3; enable_bit = 1'b1; act_thresh = 4'd5; wd_fail_cnt = 4'd5;
        step(3);
        check("R4 count equals threshold", drv_high, 0);
        @(negedge clk);
        wd_fail_cnt = 4'd4;
        #1;
        check("R5 not yet high", drv_high, 0);
        step(1);
        check("R4 count below threshold", drv_high, 1);
        @(negedge clk);
        wd_fail_cnt = 4'd5;
        #1;
        check("R5 same-cycle drop on threshold", drv_high, 0);
        wd_fail_cnt = 4'd0; act_thresh = 4'd0;
        step(3);
        check("R4 threshold zero", drv_high, 0);
        go_idle();
    endtask

    task automatic t_same_cycle_drop();
        go_monitor();
        check("R5 high before drop", drv_high, 1);
        @(negedge clk);
        enable_bit = 1'b0;
        #1;
        check("R5 same-cycle drop on enable", drv_high, 0);
        enable_bit = 1'b1;
        step(8);
        @(negedge clk);
        dev_state = 3'd5;
        #1;
        check("R5 same-cycle drop on state", drv_high, 0);
        go_idle();
    endtask

    task automatic t_selftest();
        go_monitor();
        @(negedge clk);
        ot_irq_en = 4'd0; selftest_run = 1'b1;
        step(3);
        check("R6 no ot enable", drv_high, 1);
        @(negedge clk);
        ot_irq_en = 4'b0100;
        #1;
        check("R6 forced low", drv_high, 0);
        pull_low = 1'b1;
        step(5);
        check("R6 held low", drv_high, 0);
        check("R7 no error during test", drv_err, 0);
        @(negedge clk);
        selftest_run = 1'b0;
        pull_low = 1'b0;
        step(1);
        check("R6 recovers without rewrite", drv_high, 1);
        step(8);
        check("R7 no error after release", drv_err, 0);
        ot_irq_en = 4'd0;
        go_idle();
    endtask

    task automatic t_blanking();
        @(negedge clk);
        dev_state = 3'd3; enable_bit = 1'b1; wd_fail_cnt = 4'd0; act_thresh = 4'd4;
        step(1);
        pull_low = 1'b1;
        step(1);
        pull_low = 1'b0;
        step(10);
        check("R7 blank masks early low", drv_err, 0);
        check("R7 blank count", err_count, 0);
        go_idle();
    endtask

    task automatic t_error();
        go_monitor();
        @(negedge clk);
        pull_low = 1'b1;
        step(2);
        check("R8 not yet flagged", drv_err, 0);
        step(1);
        check("R8 flagged after sync", drv_err, 1);
        check("R9 count one", err_count, 1);
        step(3);
        check("R9 one episode counted once", err_count, 1);
        @(negedge clk);
        err_clr = 1'b1;
        step(1);
        err_clr = 1'b0;
        check("R8 set wins over clear", drv_err, 1);
        pull_low = 1'b0;
        step(3);
        check("R8 still sticky", drv_err, 1);
        @(negedge clk);
        err_clr = 1'b1;
        step(1);
        err_clr = 1'b0;
        check("R8 cleared", drv_err, 0);
        check("R9 count kept on clear", err_count, 1);
        for (int k = 0; k < 17; k++) begin
            @(negedge clk);
            pull_low = 1'b1;
            @(negedge clk);
            pull_low = 1'b0;
            step(3);
        end
        step(2);
        check("R9 saturates", err_count, 15);
        go_idle();
    endtask

    initial begin
        step(3);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        step(2);
        t_reset();
        t_state_gate();
        t_enable();
        t_threshold();
        t_same_cycle_drop();
        t_selftest();
        t_blanking();
        t_error();
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule